// File: doc/BRIEF.md
# Bank-Switching Memory Decoder

This block turns the address and control strobes of an 8-bit processor with a 64k address space into chip-selects for three memories: a boot ROM, a base RAM, and a larger expansion RAM. The expansion RAM is reached through a 32k window. In the default map the ROM fills the lower half of the address space and the base RAM fills the upper half.

Two output ports that the processor can write control the map. Port 0xC1 holds a single mode bit. When the mode bit is set, both reads and writes to the lower half go to the expansion RAM and the ROM is never selected. Port 0xFC holds four page bits. These choose which 32k page of the expansion RAM the window shows. The page bits leave the block inverted, so a register bit at 0 drives its address line high. A 128k expansion device uses only the two lowest page lines. A 512k device uses all four.

The chip-selects are pure combinational decode of the current cycle. Only the two port registers hold state.

Top module: `bank_decoder`

## Requirements
- R1: With the mode bit clear, a memory read or write with A15=0 asserts only `rom_sel`. A memory read or write with A15=1 asserts only `base_ram_sel`.
- R2: An I/O write (`iorq` and `wr` high, `mreq` low) whose low address byte is 0xC1 loads the mode bit from data bit 0 at the next rising clock edge. Data bits 7:1 have no effect on the map.
- R3: Reset (`rst_n` low) clears the mode bit and clears the page register, so `page_addr` reads 4'b1111 after reset.
- R4: With the mode bit set, a memory read or write with A15=0 asserts only `xram_sel`, and `rom_sel` stays low.
- R5: With the mode bit set, a memory read or write with A15=1 asserts only `base_ram_sel`.
- R6: An I/O write whose low address byte is 0xFC loads data bits 3:0 into the page register. `page_addr[i]` (lines B15+i) equals the inverse of page register bit i. Data bits 7:4 have no effect.
- R7: At most one select is high at any time. All selects are low when `mreq` is low or when both `rd` and `wr` are low.
- R8: The following leave both registers unchanged: an I/O write to any other low-byte address, an I/O read of either port, and a memory write to an address whose low byte matches a port. The address high byte plays no part in port decode.
- R9: The selects follow the address and strobes in the same cycle, with no register delay. Page changes appear on `page_addr` right after the clock edge that performs the port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the port registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| data_in | input | 8 | Processor data bus (write data) |
| mreq | input | 1 | Memory request, active high |
| iorq | input | 1 | I/O request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rom_sel | output | 1 | Boot ROM chip-select, active high |
| base_ram_sel | output | 1 | Base RAM chip-select, active high |
| xram_sel | output | 1 | Expansion RAM chip-select, active high |
| page_addr | output | 4 | Inverted page lines B15..B18 for the expansion RAM |

## Verification
Memory reads and writes are swept across both halves of the address space, first with the mode bit clear and then with it set. This separates the ROM path from the expansion path and shows that reads and writes decode the same way. Idle, I/O-only and strobe-less cycles check that every select stays quiet. Port writes carry noise in the unused data bits and in the address high byte, and each page value from 0 to 15 is written to check the inversion. Near-miss port addresses, I/O reads, memory writes that alias a port address, and a reset in the middle of the run each show whether a register changes when it must not.

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 4,
  parameter logic [7:0] MODE_PORT = 8'hC1,
  parameter logic [7:0] PAGE_PORT = 8'hFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    data_in,
  input  logic                 mreq,
  input  logic                 iorq,
  input  logic                 rd,
  input  logic                 wr,
  output logic                 rom_sel,
  output logic                 base_ram_sel,
  output logic                 xram_sel,
  output logic [PAGE_BITS-1:0] page_addr
);

  localparam int HI = ADDR_W - 1;

  logic                 bank_mode;
  logic [PAGE_BITS-1:0] page_reg;

  wire io_write = iorq && wr && !mreq;
  wire mode_wr  = io_write && (addr[7:0] == MODE_PORT);
  wire page_wr  = io_write && (addr[7:0] == PAGE_PORT);
  wire mem_acc  = mreq && (rd || wr);
  wire upper    = addr[HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_mode <= 1'b0;
      page_reg  <= '0;
    end else begin
      if (mode_wr) bank_mode <= data_in[0];
      if (page_wr) page_reg  <= data_in[PAGE_BITS-1:0];
    end
  end

  assign rom_sel      = mem_acc && !upper && !bank_mode;
  assign xram_sel     = mem_acc && !upper &&  bank_mode;
  assign base_ram_sel = mem_acc &&  upper;
  assign page_addr    = ~page_reg;

  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, base_ram_sel, xram_sel}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq && (rd || wr)) |-> !(rom_sel || base_ram_sel || xram_sel));

  // R4
  mode_on_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && data_in[0]) |=> !rom_sel);

  // R6
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> (page_addr == ~$past(data_in[PAGE_BITS-1:0])));

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_wr |=> $stable(page_addr));

  // R5
  upper_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_acc && upper) |-> (base_ram_sel && !xram_sel));

endmodule

// File: tb/bank_decoder_test.sv
module bank_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic mreq = 0, iorq = 0, rd = 0, wr = 0;
  logic rom_sel, base_ram_sel, xram_sel;
  logic [3:0] page_addr;

  int checks = 0;
  int failures = 0;
  bit m_mode = 0;
  int m_page = 0;

  always #2.5 clk = ~clk;

  bank_decoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
    .rom_sel(rom_sel), .base_ram_sel(base_ram_sel), .xram_sel(xram_sel),
    .page_addr(page_addr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit acc;
    string tag;
    acc = mreq && (rd || wr);
    if (!acc) tag = "R7";
    else if (addr[15]) tag = m_mode ? "R5" : "R1";
    else tag = m_mode ? "R4" : "R1";
    chk({tag, " rom"},  rom_sel,      acc && !addr[15] && !m_mode);
    chk({tag, " xram"}, xram_sel,     acc && !addr[15] &&  m_mode);
    chk({tag, " base"}, base_ram_sel, acc &&  addr[15]);
    chk("R6 page", page_addr, (~m_page) & 15);
  endtask

  task automatic step(logic [15:0] a, logic [7:0] d, bit mq, bit io, bit r, bit w);
    @(negedge clk);
    addr = a; data_in = d; mreq = mq; iorq = io; rd = r; wr = w;
    #1 compare();
    @(posedge clk);
    if (rst_n && io && w && !mq) begin
      if (a[7:0] == 8'hC1) m_mode = d[0];
      if (a[7:0] == 8'hFC) m_page = d & 15;
    end
  endtask

  task automatic mem_sweep();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h2345);
      step(a, 8'h00, 1, 0, 1, 0);
      step(a, 8'h5A, 1, 0, 0, 1);
      step(a | 16'h8000, 8'h00, 1, 0, 1, 0);
      step(a | 16'h8000, 8'hA5, 1, 0, 0, 1);
      step(a, 8'h00, 1, 0, 0, 0);
      step(a, 8'h00, 0, 1, 1, 0);
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    // R3 reset state
    chk("R3 page reset", page_addr, 4'hF);
    chk("R3 rom idle", rom_sel, 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    mem_sweep();                                   // R1, R7, R9
    step(16'h12C1, 8'hFF, 0, 1, 0, 1);             // R2 set, high byte ignored
    mem_sweep();                                   // R4, R5
    step(16'h00C0, 8'h00, 0, 1, 0, 1);             // R8 near-miss port
    step(16'h00C1, 8'h00, 0, 1, 1, 0);             // R8 io read
    step(16'h00C1, 8'h00, 1, 0, 0, 1);             // R8 memory write alias
    step(16'h0100, 8'h00, 1, 0, 1, 0);
    for (int p = 0; p < 16; p++) begin             // R6 every page
      step(16'hABFC, 8'(p | 8'hF0), 0, 1, 0, 1);
      step(16'h0000, 8'h00, 1, 0, 1, 0);
    end
    step(16'h00FD, 8'h03, 0, 1, 0, 1);             // R8
    step(16'h00FC, 8'h0A, 0, 1, 1, 0);             // R8
    step(16'h00FC, 8'h0A, 1, 0, 0, 1);             // R8
    step(16'h4000, 8'h00, 1, 0, 0, 1);
    step(16'h00C1, 8'hFE, 0, 1, 0, 1);             // R2 clear, upper bits ignored
    mem_sweep();
    step(16'h00FC, 8'h05, 0, 1, 0, 1);
    step(16'h00C1, 8'h01, 0, 1, 0, 1);
    @(negedge clk) rst_n = 1'b0;                   // R3 mid-run reset
    m_mode = 0; m_page = 0;
    step(16'h0000, 8'h00, 1, 0, 1, 0);
    @(negedge clk) rst_n = 1'b1;
    step(16'h0010, 8'h00, 1, 0, 1, 0);
    step(16'h8010, 8'h00, 1, 0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule